// File: doc/BRIEF.md
# Global Register Bank Switcher

This block keeps a single active set of global registers that the datapath reads and writes through one read port and one write port, plus a set of backing banks that hold the contents of every global set not currently in use. Whenever the selected bank changes, the block stores the active set into the storage of the bank being left and then fills the active set from the storage of the bank being entered. A bank that is left and later re-entered therefore returns with exactly the values it held.

The bank is selected in one of two ways, fixed at build time by a parameter. In the state-bit variant, three single-bit selects inside a processor-state word pick one of four banks. In the level variant, a small level number picks one of eight banks, and the three state select bits are stripped from every state write. A switch takes two clock cycles with `busy` raised. The pipeline must hold its global register accesses while `busy` is high, and the block ignores any write that arrives in that window. A write that leaves the bank unchanged starts no copy.

Top module: `gbs_top`

## Requirements
- R1: After reset every active register reads zero, `state_q`, `level_q` and `bank_q` are zero, and `busy` is low.
- R2: A register write with `busy` low changes the active register at `wr_addr` from the next cycle, and `rd_data` shows the active register at `rd_addr` without a clock delay. Register 0 always reads zero, and writes to it are discarded.
- R3: An accepted state write stores `state_wr_data & 0xF3F`. In the level variant, bits 0, 10 and 11 are cleared as well, so the stored value is `state_wr_data & 0x33E`.
- R4: In the state-bit variant, bit 0 alone selects bank 1, bit 10 alone selects bank 2, and bit 11 alone selects bank 3. Any other combination of these three bits, including none set, selects bank 0.
- R5: In the level variant, an accepted level write sets `level_q` to `level_wr_data % 8`, and `bank_q` always equals `level_q`. State writes never switch banks.
- R6: In the state-bit variant, level writes have no effect: `level_q` stays zero and no switch starts.
- R7: A write that changes the bank raises `busy` for exactly the two cycles after the accepting clock edge. In the first of those edges the active set is saved to the old bank, and in the second the active set is loaded from the new bank, so every bank keeps its contents when it is left and later re-entered.
- R8: A write that leaves the bank unchanged keeps `busy` low and leaves all active registers unchanged.
- R9: While `busy` is high, register writes, state writes and level writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_wr_en | input | 1 | State write strobe |
| state_wr_data | input | STATE_W | New processor-state value |
| level_wr_en | input | 1 | Level write strobe (level variant only) |
| level_wr_data | input | LVL_IN_W | New level value, taken modulo the bank count |
| rd_addr | input | log2(NREG) | Active register read index |
| rd_data | output | DATA_W | Active register read data |
| wr_en | input | 1 | Active register write strobe |
| wr_addr | input | log2(NREG) | Active register write index |
| wr_data | input | DATA_W | Active register write data |
| busy | output | 1 | Bank copy in progress |
| state_q | output | STATE_W | Stored masked processor state |
| level_q | output | LVL_W | Stored level (zero in the state-bit variant) |
| bank_q | output | 2 or LVL_W | Currently selected bank |

## Verification
The assertions assume that the pipeline honours `busy`. They assume that no write is expected to take effect during a switch, and that reset is held long enough for the storage to clear. The stimulus drives every strobe on the falling edge for exactly one cycle. Test writes made during a switch are placed only in the first busy cycle, which exercises the ignore path without expecting any effect. Every bank of both variants is filled and then revisited in reverse order, and the bench predicts each readback from its own bank model.

// File: rtl/gbs_pkg.sv
package gbs_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SAVE = 2'd1,
      PH_LOAD = 2'd2
   } gbs_phase_e;

   // sel = {interrupt, mmu, alternate}; exactly one set picks its bank
   function automatic logic [1:0] legacy_bank(input logic [2:0] sel);
      logic [1:0] b;
      case (sel)
         3'b001:  b = 2'd1;
         3'b010:  b = 2'd2;
         3'b100:  b = 2'd3;
         default: b = 2'd0;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/gbs_bank_select.sv
module gbs_bank_select #(
   parameter int LEVEL_MODE = 0,
   parameter int SEL_W      = 3,
   parameter int BANK_W     = 2
) (
   input  logic [SEL_W-1:0]  sel,
   output logic [BANK_W-1:0] bank
);

   generate
      if (LEVEL_MODE != 0) begin : g_level
         if (SEL_W != BANK_W) begin : g_bad_w
            $error("level variant needs SEL_W == BANK_W");
         end
         assign bank = sel;
      end else begin : g_legacy
         if (SEL_W != 3 || BANK_W != 2) begin : g_bad_w
            $error("state-bit variant needs SEL_W 3 and BANK_W 2");
         end
         assign bank = gbs_pkg::legacy_bank(sel);
      end
   endgenerate

endmodule

// File: rtl/gbs_switch_ctrl.sv
module gbs_switch_ctrl #(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [BANK_W-1:0] old_bank,
   input  logic [BANK_W-1:0] new_bank,
   output logic              busy,
   output logic              save_en,
   output logic              load_en,
   output logic [BANK_W-1:0] save_bank,
   output logic [BANK_W-1:0] load_bank
);
   import gbs_pkg::*;

   gbs_phase_e        phase_q;
   logic [BANK_W-1:0] save_q;
   logic [BANK_W-1:0] load_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         save_q  <= '0;
         load_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (req) begin
                  phase_q <= PH_SAVE;
                  save_q  <= old_bank;
                  load_q  <= new_bank;
               end
            end
            PH_SAVE: phase_q <= PH_LOAD;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy      = (phase_q != PH_IDLE);
   assign save_en   = (phase_q == PH_SAVE);
   assign load_en   = (phase_q == PH_LOAD);
   assign save_bank = save_q;
   assign load_bank = load_q;

   // R7
   save_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_en |=> load_en);

   // R7
   load_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> !busy);

   // R9
   no_req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req);

endmodule

// File: rtl/gbs_bank_store.sv
module gbs_bank_store #(
   parameter int NBANK  = 4,
   parameter int NREG   = 8,
   parameter int DATA_W = 64,
   parameter int BANK_W = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         save_en,
   input  logic [BANK_W-1:0]            save_bank,
   input  logic [NREG-1:0][DATA_W-1:0]  save_data,
   input  logic [BANK_W-1:0]            load_bank,
   output logic [NREG-1:0][DATA_W-1:0]  load_data
);

   logic [NREG-1:0][DATA_W-1:0] bank_rd [NBANK];

   generate
      if (NBANK != (1 << BANK_W)) begin : g_bad_n
         $error("NBANK must equal 2**BANK_W");
      end
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         logic [NREG-1:0][DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (save_en && (save_bank == BANK_W'(b))) begin
               q <= save_data;
            end
         end
         assign bank_rd[b] = q;
      end
   endgenerate

   assign load_data = bank_rd[load_bank];

endmodule

// File: rtl/gbs_top.sv
module gbs_top #(
   parameter int                 DATA_W     = 64,
   parameter int                 NREG       = 8,
   parameter int                 STATE_W    = 12,
   parameter int                 LVL_W      = 3,
   parameter int                 LVL_IN_W   = 8,
   parameter int                 LEVEL_MODE = 0,
   parameter int                 ALT_BIT    = 0,
   parameter int                 MMU_BIT    = 10,
   parameter int                 INTR_BIT   = 11,
   parameter logic [STATE_W-1:0] STATE_MASK = 12'hF3F,
   localparam int                AW         = $clog2(NREG),
   localparam int                BANK_W     = (LEVEL_MODE != 0) ? LVL_W : 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                state_wr_en,
   input  logic [STATE_W-1:0]  state_wr_data,
   input  logic                level_wr_en,
   input  logic [LVL_IN_W-1:0] level_wr_data,
   input  logic [AW-1:0]       rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                busy,
   output logic [STATE_W-1:0]  state_q,
   output logic [LVL_W-1:0]    level_q,
   output logic [BANK_W-1:0]   bank_q
);

   localparam int NBANK = 1 << BANK_W;
   localparam int SEL_W = (LEVEL_MODE != 0) ? LVL_W : 3;
   localparam logic [STATE_W-1:0] SEL_BITS =
      STATE_W'((1 << ALT_BIT) | (1 << MMU_BIT) | (1 << INTR_BIT));
   localparam logic [STATE_W-1:0] EFF_MASK =
      (LEVEL_MODE != 0) ? (STATE_MASK & ~SEL_BITS) : STATE_MASK;

   generate
      if (NREG < 2 || NREG != (1 << AW)) begin : g_bad_nreg
         $error("NREG must be a power of two of at least 2");
      end
      if (INTR_BIT >= STATE_W || MMU_BIT >= STATE_W || ALT_BIT >= STATE_W) begin : g_bad_bits
         $error("select bits must lie inside the state word");
      end
      if (LVL_W < 1 || LVL_IN_W < LVL_W) begin : g_bad_lvl
         $error("level widths out of range");
      end
   endgenerate

   logic                        st_acc;
   logic                        lv_acc;
   logic [STATE_W-1:0]          nxt_state;
   logic [LVL_W-1:0]            lvl_in;
   logic [LVL_W-1:0]            nxt_level;
   logic [SEL_W-1:0]            sel;
   logic [BANK_W-1:0]           nxt_bank;
   logic                        req;
   logic                        save_en;
   logic                        load_en;
   logic [BANK_W-1:0]           save_bank;
   logic [BANK_W-1:0]           load_bank;
   logic [NREG-1:0][DATA_W-1:0] act_q;
   logic [NREG-1:0][DATA_W-1:0] load_data;

   assign st_acc    = state_wr_en && !busy;
   assign lv_acc    = level_wr_en && !busy && (LEVEL_MODE != 0);
   assign nxt_state = st_acc ? (state_wr_data & EFF_MASK) : state_q;
   assign lvl_in    = LVL_W'(level_wr_data % LVL_IN_W'(1 << LVL_W));
   assign nxt_level = lv_acc ? lvl_in : level_q;

   generate
      if (LEVEL_MODE != 0) begin : g_sel_level
         assign sel = nxt_level;
      end else begin : g_sel_state
         assign sel = {nxt_state[INTR_BIT], nxt_state[MMU_BIT], nxt_state[ALT_BIT]};
      end
   endgenerate

   gbs_bank_select #(
      .LEVEL_MODE (LEVEL_MODE),
      .SEL_W      (SEL_W),
      .BANK_W     (BANK_W)
   ) u_sel (
      .sel  (sel),
      .bank (nxt_bank)
   );

   assign req = (st_acc || lv_acc) && (nxt_bank != bank_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '0;
         level_q <= '0;
         bank_q  <= '0;
      end else begin
         if (st_acc) state_q <= nxt_state;
         if (lv_acc) level_q <= nxt_level;
         if (st_acc || lv_acc) bank_q <= nxt_bank;
      end
   end

   gbs_switch_ctrl #(
      .BANK_W (BANK_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .old_bank  (bank_q),
      .new_bank  (nxt_bank),
      .busy      (busy),
      .save_en   (save_en),
      .load_en   (load_en),
      .save_bank (save_bank),
      .load_bank (load_bank)
   );

   gbs_bank_store #(
      .NBANK  (NBANK),
      .NREG   (NREG),
      .DATA_W (DATA_W),
      .BANK_W (BANK_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .save_en   (save_en),
      .save_bank (save_bank),
      .save_data (act_q),
      .load_bank (load_bank),
      .load_data (load_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (load_en) begin
         act_q    <= load_data;
         act_q[0] <= '0;
      end else if (wr_en && !busy && (wr_addr != '0)) begin
         act_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = act_q[rd_addr];

   // R2
   reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[0] == '0);

   // R8
   same_bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_acc || lv_acc) && (nxt_bank == bank_q)) |=> !busy);

   // R9
   hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(state_q) && $stable(level_q) && $stable(bank_q)));

   generate
      if (LEVEL_MODE != 0) begin : g_chk_level
         // R5
         bank_follows_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_q == BANK_W'(level_q));
      end else begin : g_chk_state
         // R6
         level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            level_q == '0);
      end
   endgenerate

endmodule

// File: tb/tb_gbs_top.sv
`timescale 1ns/1ps
module tb_gbs_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        st_en [2];
   logic [11:0] st_d  [2];
   logic        lv_en [2];
   logic [7:0]  lv_d  [2];
   logic [2:0]  ra    [2];
   logic [63:0] rd    [2];
   logic        we    [2];
   logic [2:0]  wa    [2];
   logic [63:0] wd    [2];
   logic        bsy   [2];
   logic [11:0] stq   [2];
   logic [2:0]  lvq   [2];
   logic [1:0]  bk0;
   logic [2:0]  bk1;

   gbs_top #(.LEVEL_MODE(0)) dut (
      .clk(clk), .rst_n(rst_n),
      .state_wr_en(st_en[0]), .state_wr_data(st_d[0]),
      .level_wr_en(lv_en[0]), .level_wr_data(lv_d[0]),
      .rd_addr(ra[0]), .rd_data(rd[0]),
      .wr_en(we[0]), .wr_addr(wa[0]), .wr_data(wd[0]),
      .busy(bsy[0]), .state_q(stq[0]), .level_q(lvq[0]), .bank_q(bk0));

   gbs_top #(.LEVEL_MODE(1)) dut_lvl (
      .clk(clk), .rst_n(rst_n),
      .state_wr_en(st_en[1]), .state_wr_data(st_d[1]),
      .level_wr_en(lv_en[1]), .level_wr_data(lv_d[1]),
      .rd_addr(ra[1]), .rd_data(rd[1]),
      .wr_en(we[1]), .wr_addr(wa[1]), .wr_data(wd[1]),
      .busy(bsy[1]), .state_q(stq[1]), .level_q(lvq[1]), .bank_q(bk1));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [63:0] mb [2][8][8];
   logic [63:0] ma [2][8];
   int          mbk [2];
   logic [11:0] mst [2];
   int          mlv [2];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int bank_of(input int m);
      return (m == 0) ? int'(bk0) : int'(bk1);
   endfunction

   function automatic int legacy_model(input logic [11:0] s);
      int cnt;
      cnt = int'(s[0]) + int'(s[10]) + int'(s[11]);
      if (cnt != 1) return 0;
      if (s[0]) return 1;
      if (s[10]) return 2;
      return 3;
   endfunction

   function automatic logic [63:0] pat(input int m, input int b, input int r);
      return 64'h9E37_79B9_7F4A_7C15 * 64'(m * 64 + b * 8 + r + 1);
   endfunction

   task automatic rd_chk(input int m, input int a, input string req);
      logic [63:0] e;
      ra[m] = 3'(a);
      #1;
      e = (a == 0) ? 64'd0 : ma[m][a];
      chk(rd[m] === e, req, $sformatf("mode %0d bank %0d reg %0d", m, mbk[m], a), rd[m], e);
   endtask

   task automatic reg_wr(input int m, input int a, input logic [63:0] d);
      @(negedge clk);
      we[m] = 1'b1; wa[m] = 3'(a); wd[m] = d;
      @(negedge clk);
      we[m] = 1'b0;
      if (a != 0) ma[m][a] = d;
   endtask

   // is_lvl: level write, else state write; drop: writes attempted in first busy cycle
   task automatic sw(input int m, input bit is_lvl, input int val, input bit drop);
      int  nb;
      bit  exp_sw;
      int  old;
      old = mbk[m];
      if (is_lvl) begin
         if (m == 1) mlv[m] = val % 8;
      end else begin
         mst[m] = 12'(val) & ((m == 1) ? 12'h33E : 12'hF3F);
      end
      nb = (m == 1) ? mlv[m] : legacy_model(mst[m]);
      exp_sw = (nb != old);
      @(negedge clk);
      if (is_lvl) begin lv_en[m] = 1'b1; lv_d[m] = 8'(val); end
      else begin st_en[m] = 1'b1; st_d[m] = 12'(val); end
      @(negedge clk);
      lv_en[m] = 1'b0; st_en[m] = 1'b0;
      chk(bsy[m] == exp_sw, exp_sw ? "R7" : "R8", "busy first cycle", 64'(bsy[m]), 64'(exp_sw));
      if (drop) begin
         we[m] = 1'b1; wa[m] = 3'd5; wd[m] = 64'hDEAD_BEEF_0BAD_F00D;
         st_en[m] = 1'b1; st_d[m] = 12'h800;
         lv_en[m] = 1'b1; lv_d[m] = 8'd7;
      end
      @(negedge clk);
      we[m] = 1'b0; st_en[m] = 1'b0; lv_en[m] = 1'b0;
      chk(bsy[m] == exp_sw, exp_sw ? "R7" : "R8", "busy second cycle", 64'(bsy[m]), 64'(exp_sw));
      @(negedge clk);
      chk(bsy[m] == 1'b0, "R7", "busy cleared", 64'(bsy[m]), 64'd0);
      chk(stq[m] == mst[m], drop ? "R9" : "R3", "state_q", 64'(stq[m]), 64'(mst[m]));
      chk(lvq[m] == 3'(mlv[m]), (m == 1) ? "R5" : "R6", "level_q", 64'(lvq[m]), 64'(mlv[m]));
      chk(bank_of(m) == nb, (m == 1) ? "R5" : "R4", "bank_q", 64'(bank_of(m)), 64'(nb));
      if (exp_sw) begin
         for (int r = 0; r < 8; r++) mb[m][old][r] = ma[m][r];
         for (int r = 0; r < 8; r++) ma[m][r] = mb[m][nb][r];
      end
      mbk[m] = nb;
   endtask

   task automatic go(input int m, input int b);
      if (m == 0) sw(m, 1'b0, (b == 1) ? 12'h001 : (b == 2) ? 12'h400 : (b == 3) ? 12'h800 : 12'h000, 1'b0);
      else sw(m, 1'b1, b, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int m = 0; m < 2; m++) begin
         st_en[m] = 0; st_d[m] = 0; lv_en[m] = 0; lv_d[m] = 0;
         ra[m] = 0; we[m] = 0; wa[m] = 0; wd[m] = 0;
         mbk[m] = 0; mst[m] = 0; mlv[m] = 0;
         for (int r = 0; r < 8; r++) begin
            ma[m][r] = 0;
            for (int b = 0; b < 8; b++) mb[m][b][r] = 0;
         end
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int m = 0; m < 2; m++) begin
         // R1 reset state
         chk(bsy[m] == 1'b0, "R1", "busy after reset", 64'(bsy[m]), 64'd0);
         chk(stq[m] == 12'd0, "R1", "state after reset", 64'(stq[m]), 64'd0);
         chk(bank_of(m) == 0, "R1", "bank after reset", 64'(bank_of(m)), 64'd0);
         for (int r = 0; r < 8; r++) rd_chk(m, r, "R1");
      end

      for (int m = 0; m < 2; m++) begin
         int nb;
         nb = (m == 0) ? 4 : 8;
         // R2 R7: fill every bank, including an attempted write to register 0
         for (int b = 0; b < nb; b++) begin
            go(m, b);
            for (int r = 0; r < 8; r++) reg_wr(m, r, pat(m, b, r));
            for (int r = 0; r < 8; r++) rd_chk(m, r, "R2");
         end
         // R7: revisit in reverse order, contents preserved
         for (int b = nb - 1; b >= 0; b--) begin
            go(m, b);
            for (int r = 0; r < 8; r++) rd_chk(m, r, "R7");
         end
      end

      // R4: mixed select bits fall back to bank 0
      sw(0, 1'b0, 12'h800, 1'b0);
      sw(0, 1'b0, 12'h401, 1'b0);
      sw(0, 1'b0, 12'h400, 1'b0);
      sw(0, 1'b0, 12'hC00, 1'b0);
      // R3: masking of a full state write
      sw(0, 1'b0, 12'hFFF, 1'b0);
      // R8: same bank, no copy, registers unchanged
      sw(0, 1'b0, 12'h002, 1'b0);
      for (int r = 0; r < 8; r++) rd_chk(0, r, "R8");
      // R6: level write ignored in the state-bit variant
      sw(0, 1'b1, 5, 1'b0);
      // R9: writes during busy dropped
      sw(0, 1'b0, 12'h001, 1'b1);
      for (int r = 0; r < 8; r++) rd_chk(0, r, "R9");
      go(0, 3);
      for (int r = 0; r < 8; r++) rd_chk(0, r, "R9");

      // R3 R5: state write in level variant masked and never switches
      sw(1, 1'b0, 12'hFFF, 1'b0);
      // R5: level taken modulo 8
      sw(1, 1'b1, 8'hFD, 1'b0);
      for (int r = 0; r < 8; r++) rd_chk(1, r, "R5");
      // R8: same level
      sw(1, 1'b1, 8'h05, 1'b0);
      // R9 in level variant
      sw(1, 1'b1, 8'h02, 1'b1);
      for (int r = 0; r < 8; r++) rd_chk(1, r, "R9");
      go(1, 7);
      for (int r = 0; r < 8; r++) rd_chk(1, r, "R9");
      go(1, 5);
      for (int r = 0; r < 8; r++) rd_chk(1, r, "R7");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule